// File: doc/BRIEF.md
# Exception Entry State Update Unit

This unit performs the state bookkeeping a processor core needs at the moment it takes an exception. The core presents an exception number, a small cause code with three qualifier flags, the address of the next instruction and the current machine state word. The unit then produces five values: the saved return address, the saved machine state with cause bits folded in, the data-fault status word, the new machine state word and the handler vector. It commits all five together with a one-cycle take pulse. The same pulse drives a translation-cache invalidate strobe.

The control is a three-state machine. From IDLE, a request is captured and the machine moves to EVAL. In EVAL the captured request is classified and goes one of three ways. It is taken (commit, back to IDLE). It is dropped when it is a floating-point program fault while both floating-point exception-mode bits are clear (back to IDLE). Or it is deferred when it is a maskable interrupt (external or decrementer) while the interrupt-enable bit is clear (to PEND). In PEND the unit samples the live machine state each cycle and returns to EVAL once interrupt-enable is set. Requests that arrive outside IDLE are ignored.

Exception numbers used: 1 reset, 2 machine check, 3 data-storage fault, 4 instruction-storage fault, 5 external interrupt, 6 alignment, 7 program, 8 floating-point unavailable, 9 decrementer. Any other number is taken as a plain exception that saves the next address. Machine-state bit positions (bit 0 = LSB): POW 18, ILE 16, EE 15, PR 14, FP 13, ME 12, FE0 11, SE 10, BE 9, FE1 8, IP 6, IR 5, DR 4, RI 1, LE 0.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset, take_o, tlb_inv_o and pend_o are 0, and srr0_o, srr1_o, dsisr_o, msr_o and vector_o are all zero.
- R2: A request accepted in IDLE at clock edge k that is neither deferred nor dropped raises take_o and tlb_inv_o together for exactly one cycle after edge k+1, with all result outputs updated at that same edge.
- R3: vector_o is the exception number shifted left by 8. For reset (1) with IP (bit 6) set, 0xFFC00000 is ORed in.
- R4: msr_o is the input state with POW, EE, PR, FP, FE0, SE, BE, FE1, IR, DR and RI cleared and LE set to the ILE value. Machine check (2) also clears ME. All other bits are kept.
- R5: srr0_o is next address minus 4 for alignment (6), program (7) and floating-point unavailable (8). It is left unchanged for machine check (2) and equals the next address for every other number.
- R6: For numbers 3, 4 and 7, srr1_o is the state word with its upper 16 bits cleared plus cause bits. For all other numbers it is the state word unchanged.
- R7: Instruction-storage cause: code 1 (not found) sets bit 30; codes 2 (no-execute), 3 (guarded) and 4 (direct-store) set bit 28; any other code sets bit 27.
- R8: Program cause: bit 16 is always set; code 1 (floating point) adds bit 20, code 2 (illegal) bit 19, code 3 (privileged) bit 18, code 4 (trap) bit 17; other codes add nothing.
- R9: On a data-storage fault, dsisr_o is rebuilt. Code 1 sets bit 30; otherwise code 2 sets bit 27; otherwise code 3 sets bit 31, plus bit 26 when direct_i is set. store_i adds bit 25 and extctl_i adds bit 20. Other numbers leave dsisr_o unchanged.
- R10: External (5) or decrementer (9) with EE clear is not taken. pend_o stays high until EE is seen set on msr_i, and then the request is taken using the state sampled at that point.
- R11: Program with code 1 while FE0 and FE1 are both clear is dropped: no take pulse, no pending state, outputs unchanged.
- R12: A request presented while the unit is not in IDLE is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Exception request, sampled in IDLE |
| exc_num_i | input | NUM_W | Exception number |
| cause_i | input | CAUSE_W | Cause code |
| store_i | input | 1 | Faulting access was a store |
| direct_i | input | 1 | Faulting access targeted a direct-store segment |
| extctl_i | input | 1 | Faulting access was an external-control transfer |
| nia_i | input | XLEN | Next-instruction address |
| msr_i | input | XLEN | Current machine state word |
| take_o | output | 1 | One-cycle commit pulse |
| tlb_inv_o | output | 1 | Translation invalidate strobe, with take |
| pend_o | output | 1 | A masked interrupt is waiting |
| srr0_o | output | XLEN | Saved return address |
| srr1_o | output | XLEN | Saved machine state with cause bits |
| dsisr_o | output | XLEN | Data-fault status word |
| msr_o | output | XLEN | New machine state word |
| vector_o | output | XLEN | Handler address |

## Verification
The main sweep crosses exception numbers 0 to 15 with all eight cause codes and all eight flag combinations, under three state words. The all-ones word separates the cleared bits from the kept ones and enables the reset high vector. The sparse word with both FE bits clear and ILE clear exposes the drop rule and LE copying of a zero. The mixed word checks that the bits kept in srr1 are exactly the lower half. Each flag pattern tells apart the priority chain of data-fault causes from the independent store and external-control bits. Directed cases hold a masked external interrupt pending while another request arrives, to show it is ignored, and then release it with a new state word, to show that state is re-sampled.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    // Machine-state bit positions
    localparam int MSR_POW = 18;
    localparam int MSR_ILE = 16;
    localparam int MSR_EE  = 15;
    localparam int MSR_PR  = 14;
    localparam int MSR_FP  = 13;
    localparam int MSR_ME  = 12;
    localparam int MSR_FE0 = 11;
    localparam int MSR_SE  = 10;
    localparam int MSR_BE  = 9;
    localparam int MSR_FE1 = 8;
    localparam int MSR_IP  = 6;
    localparam int MSR_IR  = 5;
    localparam int MSR_DR  = 4;
    localparam int MSR_RI  = 1;
    localparam int MSR_LE  = 0;

    // Data-fault status bit positions
    localparam int DS_UNSUP    = 31;
    localparam int DS_NOTFOUND = 30;
    localparam int DS_PROT     = 27;
    localparam int DS_DIRECT   = 26;
    localparam int DS_STORE    = 25;
    localparam int DS_EXTCTL   = 20;

    // Saved-state cause bit positions
    localparam int SV_ISI_NOTFOUND = 30;
    localparam int SV_ISI_NOEXEC   = 28;
    localparam int SV_ISI_PROT     = 27;
    localparam int SV_PRG_FP       = 20;
    localparam int SV_PRG_ILL      = 19;
    localparam int SV_PRG_PRIV     = 18;
    localparam int SV_PRG_TRAP     = 17;
    localparam int SV_PRG_ANY      = 16;

    // Cause codes
    localparam int CC_NOTFOUND = 1;
    localparam int CC_PROT     = 2;
    localparam int CC_UNSUP    = 3;
    localparam int CC_NOEXEC   = 2;
    localparam int CC_GUARD    = 3;
    localparam int CC_DSTORE   = 4;
    localparam int CC_FP       = 1;
    localparam int CC_ILL      = 2;
    localparam int CC_PRIV     = 3;
    localparam int CC_TRAP     = 4;

    localparam logic [31:0] RESET_HIGH_BASE = 32'hFFC0_0000;
    localparam int          VEC_SHIFT       = 8;

    typedef enum logic [3:0] {
        K_OTHER, K_RESET, K_MCHK, K_DSI, K_ISI,
        K_EXT, K_ALIGN, K_PROG, K_NOFP, K_DEC
    } exc_kind_t;

    typedef enum logic [1:0] {ST_IDLE, ST_EVAL, ST_PEND} fsm_t;

    typedef enum logic [1:0] {SAVE_NEXT, SAVE_CUR, SAVE_KEEP} save_sel_t;

    // Bits cleared in the new machine state on every entry
    function automatic logic [31:0] entry_clear_mask();
        logic [31:0] m;
        m = '0;
        m[MSR_POW] = 1'b1; m[MSR_EE]  = 1'b1; m[MSR_PR]  = 1'b1;
        m[MSR_FP]  = 1'b1; m[MSR_FE0] = 1'b1; m[MSR_SE]  = 1'b1;
        m[MSR_BE]  = 1'b1; m[MSR_FE1] = 1'b1; m[MSR_IR]  = 1'b1;
        m[MSR_DR]  = 1'b1; m[MSR_RI]  = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/exc_kind_decode.sv
module exc_kind_decode
    import exc_entry_pkg::*;
#(
    parameter int NUM_W = 5
) (
    input  logic [NUM_W-1:0] num_i,
    output exc_kind_t        kind_o,
    output save_sel_t        save_o,
    output logic             maskable_o
);

    always_comb begin
        unique case (num_i)
            NUM_W'(1): kind_o = K_RESET;
            NUM_W'(2): kind_o = K_MCHK;
            NUM_W'(3): kind_o = K_DSI;
            NUM_W'(4): kind_o = K_ISI;
            NUM_W'(5): kind_o = K_EXT;
            NUM_W'(6): kind_o = K_ALIGN;
            NUM_W'(7): kind_o = K_PROG;
            NUM_W'(8): kind_o = K_NOFP;
            NUM_W'(9): kind_o = K_DEC;
            default:   kind_o = K_OTHER;
        endcase
    end

    always_comb begin
        unique case (kind_o)
            K_ALIGN, K_PROG, K_NOFP: save_o = SAVE_CUR;
            K_MCHK:                  save_o = SAVE_KEEP;
            default:                 save_o = SAVE_NEXT;
        endcase
        maskable_o = (kind_o == K_EXT) || (kind_o == K_DEC);
    end

endmodule

// File: rtl/exc_cause_encode.sv
module exc_cause_encode
    import exc_entry_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 3
) (
    input  exc_kind_t          kind_i,
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic               store_i,
    input  logic               direct_i,
    input  logic               extctl_i,
    input  logic [XLEN-1:0]    msr_i,
    output logic [XLEN-1:0]    srr1_o,
    output logic [XLEN-1:0]    dsisr_o,
    output logic               dsisr_we_o,
    output logic               drop_o
);

    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] low_half;
    assign low_half = {{(XLEN-HALF){1'b0}}, msr_i[HALF-1:0]};

    always_comb begin
        srr1_o     = msr_i;
        dsisr_o    = '0;
        dsisr_we_o = 1'b0;
        drop_o     = 1'b0;
        unique case (kind_i)
            K_DSI: begin
                srr1_o     = low_half;
                dsisr_we_o = 1'b1;
                if (cause_i == CAUSE_W'(CC_NOTFOUND)) begin
                    dsisr_o[DS_NOTFOUND] = 1'b1;
                end else if (cause_i == CAUSE_W'(CC_PROT)) begin
                    dsisr_o[DS_PROT] = 1'b1;
                end else if (cause_i == CAUSE_W'(CC_UNSUP)) begin
                    dsisr_o[DS_UNSUP]  = 1'b1;
                    dsisr_o[DS_DIRECT] = direct_i;
                end
                if (store_i)  dsisr_o[DS_STORE]  = 1'b1;
                if (extctl_i) dsisr_o[DS_EXTCTL] = 1'b1;
            end
            K_ISI: begin
                srr1_o = low_half;
                if (cause_i == CAUSE_W'(CC_NOTFOUND))
                    srr1_o[SV_ISI_NOTFOUND] = 1'b1;
                else if (cause_i == CAUSE_W'(CC_NOEXEC) ||
                         cause_i == CAUSE_W'(CC_GUARD)  ||
                         cause_i == CAUSE_W'(CC_DSTORE))
                    srr1_o[SV_ISI_NOEXEC] = 1'b1;
                else
                    srr1_o[SV_ISI_PROT] = 1'b1;
            end
            K_PROG: begin
                srr1_o = low_half;
                srr1_o[SV_PRG_ANY] = 1'b1;
                if (cause_i == CAUSE_W'(CC_FP)) begin
                    srr1_o[SV_PRG_FP] = 1'b1;
                    drop_o = !msr_i[MSR_FE0] && !msr_i[MSR_FE1];
                end else if (cause_i == CAUSE_W'(CC_ILL)) begin
                    srr1_o[SV_PRG_ILL] = 1'b1;
                end else if (cause_i == CAUSE_W'(CC_PRIV)) begin
                    srr1_o[SV_PRG_PRIV] = 1'b1;
                end else if (cause_i == CAUSE_W'(CC_TRAP)) begin
                    srr1_o[SV_PRG_TRAP] = 1'b1;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/exc_state_build.sv
module exc_state_build
    import exc_entry_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int NUM_W = 5
) (
    input  exc_kind_t        kind_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [XLEN-1:0]  msr_i,
    output logic [XLEN-1:0]  msr_o,
    output logic [XLEN-1:0]  vector_o
);

    localparam logic [XLEN-1:0] CLR = XLEN'(entry_clear_mask());

    always_comb begin
        msr_o         = msr_i & ~CLR;
        msr_o[MSR_LE] = msr_i[MSR_ILE];
        if (kind_i == K_MCHK)
            msr_o[MSR_ME] = 1'b0;
    end

    always_comb begin
        vector_o = XLEN'(num_i) << VEC_SHIFT;
        if (kind_i == K_RESET && msr_i[MSR_IP])
            vector_o = vector_o | XLEN'(RESET_HIGH_BASE);
    end

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_entry_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int NUM_W   = 5,
    parameter int CAUSE_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic [NUM_W-1:0]   exc_num_i,
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic               store_i,
    input  logic               direct_i,
    input  logic               extctl_i,
    input  logic [XLEN-1:0]    nia_i,
    input  logic [XLEN-1:0]    msr_i,
    output logic               take_o,
    output logic               tlb_inv_o,
    output logic               pend_o,
    output logic [XLEN-1:0]    srr0_o,
    output logic [XLEN-1:0]    srr1_o,
    output logic [XLEN-1:0]    dsisr_o,
    output logic [XLEN-1:0]    msr_o,
    output logic [XLEN-1:0]    vector_o
);

    localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

    fsm_t state_q, state_d;

    logic [NUM_W-1:0]   num_q;
    logic [CAUSE_W-1:0] cause_q;
    logic               store_q, direct_q, ext_q;
    logic [XLEN-1:0]    nia_q, msr_q;

    exc_kind_t       kind;
    save_sel_t       save_sel;
    logic            maskable, drop, dsisr_we;
    logic [XLEN-1:0] srr1_d, dsisr_d, msr_d, vector_d, srr0_d;
    logic            defer, commit;

    exc_kind_decode #(.NUM_W(NUM_W)) u_decode (
        .num_i      (num_q),
        .kind_o     (kind),
        .save_o     (save_sel),
        .maskable_o (maskable)
    );

    exc_cause_encode #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_cause (
        .kind_i     (kind),
        .cause_i    (cause_q),
        .store_i    (store_q),
        .direct_i   (direct_q),
        .extctl_i   (ext_q),
        .msr_i      (msr_q),
        .srr1_o     (srr1_d),
        .dsisr_o    (dsisr_d),
        .dsisr_we_o (dsisr_we),
        .drop_o     (drop)
    );

    exc_state_build #(.XLEN(XLEN), .NUM_W(NUM_W)) u_build (
        .kind_i   (kind),
        .num_i    (num_q),
        .msr_i    (msr_q),
        .msr_o    (msr_d),
        .vector_o (vector_d)
    );

    assign defer  = maskable && !msr_q[MSR_EE];
    assign commit = (state_q == ST_EVAL) && !defer && !drop;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_i) state_d = ST_EVAL;
            ST_EVAL: state_d = defer ? ST_PEND : ST_IDLE;
            ST_PEND: if (msr_i[MSR_EE]) state_d = ST_EVAL;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request capture and re-sampling while pending
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            num_q    <= '0;
            cause_q  <= '0;
            store_q  <= 1'b0;
            direct_q <= 1'b0;
            ext_q    <= 1'b0;
            nia_q    <= '0;
            msr_q    <= '0;
        end else if (state_q == ST_IDLE && req_i) begin
            num_q    <= exc_num_i;
            cause_q  <= cause_i;
            store_q  <= store_i;
            direct_q <= direct_i;
            ext_q    <= extctl_i;
            nia_q    <= nia_i;
            msr_q    <= msr_i;
        end else if (state_q == ST_PEND) begin
            msr_q    <= msr_i;
        end
    end

    always_comb begin
        srr0_d = srr0_o;
        unique case (save_sel)
            SAVE_NEXT: srr0_d = nia_q;
            SAVE_CUR:  srr0_d = nia_q - INSN_BYTES;
            SAVE_KEEP: srr0_d = srr0_o;
            default:   srr0_d = srr0_o;
        endcase
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o    <= 1'b0;
            tlb_inv_o <= 1'b0;
            srr0_o    <= '0;
            srr1_o    <= '0;
            dsisr_o   <= '0;
            msr_o     <= '0;
            vector_o  <= '0;
        end else begin
            take_o    <= commit;
            tlb_inv_o <= commit;
            if (commit) begin
                srr0_o   <= srr0_d;
                srr1_o   <= srr1_d;
                msr_o    <= msr_d;
                vector_o <= vector_d;
                if (dsisr_we) dsisr_o <= dsisr_d;
            end
        end
    end

    assign pend_o = (state_q == ST_PEND);

    // Checks
    assert_take_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);
    assert_inv_follows_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_o) |-> tlb_inv_o);
    assert_vec_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (vector_o[VEC_SHIFT-1:0] == '0));
    assert_ee_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> !msr_o[MSR_EE] && !msr_o[MSR_PR] && (msr_o[MSR_LE] == msr_o[MSR_ILE]));
    assert_srr0_on_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(srr0_o) |-> take_o);
    assert_dsisr_on_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dsisr_o) |-> take_o);
    assert_pend_blocks_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pend_o |-> !take_o);

endmodule

// File: tb/tb_exc_entry_unit.sv
`timescale 1ns/1ps
module tb_exc_entry_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [4:0]  exc_num_i = '0;
    logic [2:0]  cause_i = '0;
    logic        store_i = 1'b0, direct_i = 1'b0, extctl_i = 1'b0;
    logic [31:0] nia_i = '0, msr_i = '0;
    logic        take_o, tlb_inv_o, pend_o;
    logic [31:0] srr0_o, srr1_o, dsisr_o, msr_o, vector_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [31:0] prev_srr0 = '0, prev_dsisr = '0;

    always #4 clk = ~clk;

    exc_entry_unit dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .exc_num_i(exc_num_i),
        .cause_i(cause_i), .store_i(store_i), .direct_i(direct_i),
        .extctl_i(extctl_i), .nia_i(nia_i), .msr_i(msr_i),
        .take_o(take_o), .tlb_inv_o(tlb_inv_o), .pend_o(pend_o),
        .srr0_o(srr0_o), .srr1_o(srr1_o), .dsisr_o(dsisr_o),
        .msr_o(msr_o), .vector_o(vector_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] bitv(input int b);
        return 32'd1 << b;
    endfunction

    function automatic logic [31:0] model_msr(input int n, input logic [31:0] m);
        logic [31:0] clr, r;
        clr = bitv(18) + bitv(15) + bitv(14) + bitv(13) + bitv(11) + bitv(10)
            + bitv(9) + bitv(8) + bitv(5) + bitv(4) + bitv(1);
        if (n == 2) clr = clr + bitv(12);
        r = m & ~clr;
        r = (r & ~32'd1) | ((m >> 16) & 32'd1);
        return r;
    endfunction

    function automatic logic [31:0] model_srr1(input int n, input int c, input logic [31:0] m);
        logic [31:0] r;
        if (n != 3 && n != 4 && n != 7) return m;
        r = m % 32'h0001_0000;
        if (n == 4) begin
            if (c == 1)                  r = r + 32'h4000_0000;
            else if (c >= 2 && c <= 4)   r = r + 32'h1000_0000;
            else                         r = r + 32'h0800_0000;
        end else if (n == 7) begin
            r = r + 32'h0001_0000;
            case (c)
                1: r = r + 32'h0010_0000;
                2: r = r + 32'h0008_0000;
                3: r = r + 32'h0004_0000;
                4: r = r + 32'h0002_0000;
                default: ;
            endcase
        end
        return r;
    endfunction

    function automatic logic [31:0] model_dsisr(input int c, input int f);
        logic [31:0] r;
        r = 0;
        if (c == 1)      r = 32'h4000_0000;
        else if (c == 2) r = 32'h0800_0000;
        else if (c == 3) r = 32'h8000_0000 + ((f >> 1) & 1) * 32'h0400_0000;
        r = r + (f & 1) * 32'h0200_0000 + ((f >> 2) & 1) * 32'h0010_0000;
        return r;
    endfunction

    // flags f: bit0 store, bit1 direct, bit2 external-control
    task automatic run_one(input int n, input int c, input int f,
                           input logic [31:0] m, input logic [31:0] a);
        logic drop;
        logic [31:0] e_srr0, e_dsisr, e_vec;
        string t6;
        drop = (n == 7) && (c == 1) && !m[11] && !m[8];
        if (n == 6 || n == 7 || n == 8) e_srr0 = a - 32'd4;
        else if (n == 2)                e_srr0 = prev_srr0;
        else                            e_srr0 = a;
        e_dsisr = (n == 3) ? model_dsisr(c, f) : prev_dsisr;
        e_vec = 32'(n) * 32'd256;
        if (n == 1 && m[6]) e_vec = e_vec | 32'hFFC0_0000;
        t6 = (n == 4) ? "R7 srr1" : (n == 7) ? "R8 srr1" : "R6 srr1";

        @(negedge clk);
        req_i = 1'b1; exc_num_i = 5'(n); cause_i = 3'(c);
        store_i = f[0]; direct_i = f[1]; extctl_i = f[2];
        nia_i = a; msr_i = m;
        @(negedge clk);
        req_i = 1'b0;
        @(negedge clk);
        if (drop) begin
            chk("R11 take", {31'd0, take_o}, 32'd0);
            chk("R11 pend", {31'd0, pend_o}, 32'd0);
            chk("R11 srr0", srr0_o, prev_srr0);
        end else begin
            chk("R2 take", {31'd0, take_o}, 32'd1);
            chk("R2 tlb_inv", {31'd0, tlb_inv_o}, 32'd1);
            chk("R5 srr0", srr0_o, e_srr0);
            chk(t6, srr1_o, model_srr1(n, c, m));
            chk("R9 dsisr", dsisr_o, e_dsisr);
            chk("R4 msr", msr_o, model_msr(n, m));
            chk("R3 vector", vector_o, e_vec);
            prev_srr0 = e_srr0;
            prev_dsisr = e_dsisr;
            @(negedge clk);
            chk("R2 take one cycle", {31'd0, take_o}, 32'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] pats [3];
        pats[0] = 32'hFFFF_FFFF;
        pats[1] = 32'h0000_8040;
        pats[2] = 32'h0001_9B21;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        chk("R1 take", {31'd0, take_o}, 32'd0);
        chk("R1 tlb_inv", {31'd0, tlb_inv_o}, 32'd0);
        chk("R1 pend", {31'd0, pend_o}, 32'd0);
        chk("R1 srr0", srr0_o, 32'd0);
        chk("R1 srr1", srr1_o, 32'd0);
        chk("R1 dsisr", dsisr_o, 32'd0);
        chk("R1 msr", msr_o, 32'd0);
        chk("R1 vector", vector_o, 32'd0);

        for (int p = 0; p < 3; p++)
            for (int n = 0; n < 16; n++)
                for (int c = 0; c < 8; c++)
                    for (int f = 0; f < 8; f++)
                        run_one(n, c, f, pats[p],
                                32'h1000_0000 + 32'((p * 1024 + n * 64 + c * 8 + f) * 16));

        // R10 deferral of an external interrupt, R12 request while pending
        @(negedge clk);
        req_i = 1'b1; exc_num_i = 5'd5; cause_i = 3'd0;
        store_i = 1'b0; direct_i = 1'b0; extctl_i = 1'b0;
        nia_i = 32'h0000_4000; msr_i = 32'h0001_0000;
        @(negedge clk);
        req_i = 1'b0;
        @(negedge clk);
        chk("R10 pend raised", {31'd0, pend_o}, 32'd1);
        chk("R10 no take", {31'd0, take_o}, 32'd0);
        req_i = 1'b1; exc_num_i = 5'd9; nia_i = 32'h0000_8888;
        @(negedge clk);
        req_i = 1'b0;
        repeat (3) @(negedge clk);
        chk("R12 still pending", {31'd0, pend_o}, 32'd1);
        chk("R12 no take", {31'd0, take_o}, 32'd0);
        chk("R12 srr0 held", srr0_o, prev_srr0);
        msr_i = 32'h0001_8000;
        @(negedge clk);
        chk("R10 leaves pend", {31'd0, pend_o}, 32'd0);
        @(negedge clk);
        chk("R10 take", {31'd0, take_o}, 32'd1);
        chk("R12 vector of first", vector_o, 32'h0000_0500);
        chk("R12 srr0 of first", srr0_o, 32'h0000_4000);
        chk("R10 srr1 resampled", srr1_o, 32'h0001_8000);
        chk("R10 msr", msr_o, 32'h0001_0001);
        prev_srr0 = 32'h0000_4000;
        msr_i = 32'h0;

        // R10 decrementer deferral
        @(negedge clk);
        req_i = 1'b1; exc_num_i = 5'd9; nia_i = 32'h0000_6000; msr_i = 32'h0000_0000;
        @(negedge clk);
        req_i = 1'b0;
        @(negedge clk);
        chk("R10 dec pend", {31'd0, pend_o}, 32'd1);
        msr_i = 32'h0000_8000;
        repeat (2) @(negedge clk);
        chk("R10 dec take", {31'd0, take_o}, 32'd1);
        chk("R10 dec vector", vector_o, 32'h0000_0900);
        chk("R10 dec srr0", srr0_o, 32'h0000_6000);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule